// File: doc/BRIEF.md
# Wall-Following Navigation Controller

This block is the steering brain of a small maze robot that keeps a wall on its right-hand side. It reads two touch sensors, one on each antenna. A sensor reads 1 while its antenna is in contact with a wall. The block drives three actuator commands: step forward, veer left slightly and veer right slightly. It is a Moore machine with four states. The actuator commands are decoded from the registered state alone, so they change only at a clock edge.

The four states are as follows. SEARCH means the robot has lost the wall and walks straight until it bumps into something. PIVOT means it turns left on the spot until both antennae are clear. HUG means it follows the wall while touching it, easing left. AWAY means it follows the wall while not touching it, easing right to find the wall again. The current state code is also brought out on a port so that the robot's supervisor can observe it.

Top module: `wf_wall_follower`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine enters SEARCH (state code 2'b00) at that edge, whatever the sensors read. SEARCH then drives `step_fwd`=1, `veer_left`=0 and `veer_right`=0.
- R2: The actuator commands depend only on the state: SEARCH gives forward only; PIVOT gives veer-left only; HUG gives veer-left and forward; AWAY gives veer-right and forward.
- R3: In SEARCH, if either sensor reads 1 the next state is PIVOT; if both read 0 it stays in SEARCH.
- R4: In PIVOT, the machine stays in PIVOT while either sensor reads 1, and moves to AWAY when both read 0.
- R5: In HUG, a left contact moves to PIVOT whatever the right sensor reads. A right contact alone keeps HUG. No contact moves to AWAY.
- R6: In AWAY, a right contact moves to HUG. Otherwise the machine stays in AWAY, and a left contact alone has no effect.
- R7: A sensor change between clock edges does not change any output before the next rising edge.
- R8: `state_code` reports SEARCH=2'b00, PIVOT=2'b01, HUG=2'b10 and AWAY=2'b11; all four codes are reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| touch_left | input | 1 | Left antenna in contact with a wall |
| touch_right | input | 1 | Right antenna in contact with a wall |
| step_fwd | output | 1 | Command: step forward |
| veer_left | output | 1 | Command: turn slightly left |
| veer_right | output | 1 | Command: turn slightly right |
| state_code | output | 2 | Registered state code |

## Verification
The bound checker checks on every cycle that the commands match the registered state. It also checks each transition rule of R3 to R6 one cycle after the sensors are sampled, and that the commands hold steady whenever the state holds. The bench reaches every state through a scripted sensor path and applies all four sensor combinations in each one, so all sixteen transitions are covered. It also shows what only stimulus can show: the reset entry with the sensors active, outputs that do not move when the sensors toggle between edges, and a long pseudo-random walk compared cycle by cycle against an arithmetic model.

// File: rtl/wf_pkg.sv
// Shared types for the wall-following controller.
// Assumes a two-bit state code in which every code is a legal state.
package wf_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        WF_SEARCH = 2'b00,
        WF_PIVOT  = 2'b01,
        WF_HUG    = 2'b10,
        WF_AWAY   = 2'b11
    } wf_state_t;

    typedef struct packed {
        logic fwd;
        logic left;
        logic right;
    } wf_cmd_t;

endpackage

// File: rtl/wf_next_state.sv
// Next-state function of the wall follower.
// Pure combinational logic; assumes the sensor inputs are already synchronous.
module wf_next_state
    import wf_pkg::*;
(
    input  wf_state_t cur_state,
    input  logic      sense_l,
    input  logic      sense_r,
    output wf_state_t nxt_state
);

    logic any_contact;

    // Either antenna touching.
    always_comb any_contact = sense_l | sense_r;

    // Transition table by current state.
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            WF_SEARCH: nxt_state = any_contact ? WF_PIVOT : WF_SEARCH;
            WF_PIVOT:  nxt_state = any_contact ? WF_PIVOT : WF_AWAY;
            WF_HUG: begin
                if (sense_l)      nxt_state = WF_PIVOT;
                else if (sense_r) nxt_state = WF_HUG;
                else              nxt_state = WF_AWAY;
            end
            WF_AWAY:   nxt_state = sense_r ? WF_HUG : WF_AWAY;
            default:   nxt_state = WF_SEARCH;
        endcase
    end

endmodule

// File: rtl/wf_state_reg.sv
// State register with synchronous active-low reset to SEARCH.
// Assumes rst_n is synchronous to clk.
module wf_state_reg
    import wf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wf_state_t nxt_state,
    output wf_state_t cur_state
);

    // Capture the next state, or return to SEARCH under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_state <= WF_SEARCH;
        else        cur_state <= nxt_state;
    end

endmodule

// File: rtl/wf_out_decode.sv
// Moore output decoder: actuator commands from the state alone.
// Assumes no input other than the state may reach the outputs.
module wf_out_decode
    import wf_pkg::*;
(
    input  wf_state_t cur_state,
    output wf_cmd_t   cmd
);

    // One fixed command set per state.
    always_comb begin
        cmd = '{fwd: 1'b1, left: 1'b0, right: 1'b0};
        unique case (cur_state)
            WF_SEARCH: cmd = '{fwd: 1'b1, left: 1'b0, right: 1'b0};
            WF_PIVOT:  cmd = '{fwd: 1'b0, left: 1'b1, right: 1'b0};
            WF_HUG:    cmd = '{fwd: 1'b1, left: 1'b1, right: 1'b0};
            WF_AWAY:   cmd = '{fwd: 1'b1, left: 1'b0, right: 1'b1};
            default:   cmd = '{fwd: 1'b1, left: 1'b0, right: 1'b0};
        endcase
    end

endmodule

// File: rtl/wf_wall_follower.sv
// Top level of the wall-following controller: next-state logic, state
// register and output decoder. Assumes synchronous sensors and reset.
module wf_wall_follower
    import wf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_left,
    input  logic               touch_right,
    output logic               step_fwd,
    output logic               veer_left,
    output logic               veer_right,
    output logic [STATE_W-1:0] state_code
);

    wf_state_t cur_state;
    wf_state_t nxt_state;
    wf_cmd_t   cmd;

    wf_next_state u_next (
        .cur_state (cur_state),
        .sense_l   (touch_left),
        .sense_r   (touch_right),
        .nxt_state (nxt_state)
    );

    wf_state_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    wf_out_decode u_dec (
        .cur_state (cur_state),
        .cmd       (cmd)
    );

    // Drive the ports from the decoded command and state.
    always_comb begin
        step_fwd   = cmd.fwd;
        veer_left  = cmd.left;
        veer_right = cmd.right;
        state_code = cur_state;
    end

endmodule

// File: rtl/wf_wall_follower_chk.sv
// Assertion checker for the wall-following controller, bound to the top.
// Assumes the state codes 00/01/10/11 for SEARCH/PIVOT/HUG/AWAY.
module wf_wall_follower_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       touch_left,
    input logic       touch_right,
    input logic       step_fwd,
    input logic       veer_left,
    input logic       veer_right,
    input logic [1:0] state_code
);

    logic rst_prev;

    // Remember whether reset was low at the previous edge.
    always_ff @(posedge clk) rst_prev <= !rst_n;

    // R1
    always @(negedge clk) begin
        if (rst_prev === 1'b1)
            reset_entry_chk: assert (state_code == 2'b00 && step_fwd && !veer_left && !veer_right);
    end

    // R2
    search_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b00 |-> (step_fwd && !veer_left && !veer_right));
    // R2
    pivot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b01 |-> (!step_fwd && veer_left && !veer_right));
    // R2
    hug_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b10 |-> (step_fwd && veer_left && !veer_right));
    // R2
    away_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b11 |-> (step_fwd && !veer_left && veer_right));

    // R3
    search_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b00) |=> (state_code == ($past(touch_left || touch_right) ? 2'b01 : 2'b00)));
    // R4
    pivot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b01) |=> (state_code == ($past(touch_left || touch_right) ? 2'b01 : 2'b11)));
    // R5
    hug_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b10 && touch_left) |=> state_code == 2'b01);
    // R5
    hug_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b10 && !touch_left) |=> (state_code == ($past(touch_right) ? 2'b10 : 2'b11)));
    // R6
    away_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b11) |=> (state_code == ($past(touch_right) ? 2'b10 : 2'b11)));
    // R7
    moore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state_code) |-> ($stable(step_fwd) && $stable(veer_left) && $stable(veer_right)));

endmodule

bind wf_wall_follower wf_wall_follower_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_left  (touch_left),
    .touch_right (touch_right),
    .step_fwd    (step_fwd),
    .veer_left   (veer_left),
    .veer_right  (veer_right),
    .state_code  (state_code)
);

// File: tb/tb_wf_wall_follower.sv
module tb_wf_wall_follower;

    localparam int CLK_PERIOD = 10;
    localparam int WALK_LEN   = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       touch_left = 1'b0;
    logic       touch_right = 1'b0;
    logic       step_fwd, veer_left, veer_right;
    logic [1:0] state_code;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_state = 2'b00;

    wf_wall_follower dut (
        .clk(clk), .rst_n(rst_n),
        .touch_left(touch_left), .touch_right(touch_right),
        .step_fwd(step_fwd), .veer_left(veer_left), .veer_right(veer_right),
        .state_code(state_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected next state from the requirements (R3..R6)
    function automatic logic [1:0] model_next(input logic [1:0] s, input logic l, input logic r);
        case (s)
            2'b00:   return (l | r) ? 2'b01 : 2'b00;
            2'b01:   return (l | r) ? 2'b01 : 2'b11;
            2'b10:   return l ? 2'b01 : (r ? 2'b10 : 2'b11);
            default: return r ? 2'b10 : 2'b11;
        endcase
    endfunction

    // Expected {fwd,left,right} per state (R2)
    function automatic logic [2:0] model_cmd(input logic [1:0] s);
        case (s)
            2'b00:   return 3'b100;
            2'b01:   return 3'b010;
            2'b10:   return 3'b110;
            default: return 3'b101;
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] exp_s);
        logic [2:0] act_c;
        logic [2:0] exp_c;
        act_c = {step_fwd, veer_left, veer_right};
        exp_c = model_cmd(exp_s);
        checks++;
        if (state_code !== exp_s || act_c !== exp_c) begin
            errors++;
            $display("FAIL %s: state=%b cmd=%b expected state=%b cmd=%b",
                     req, state_code, act_c, exp_s, exp_c);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        touch_left = 1'b1;
        touch_right = 1'b1;
        tick();
        exp_state = 2'b00;
        rst_n = 1'b1;
    endtask

    // Reach a given state from reset along a fixed sensor path.
    task automatic reach(input logic [1:0] target);
        do_reset();
        if (target == 2'b00) return;
        touch_left = 1'b1; touch_right = 1'b0; tick();
        if (target == 2'b01) begin exp_state = 2'b01; return; end
        touch_left = 1'b0; touch_right = 1'b0; tick();
        if (target == 2'b11) begin exp_state = 2'b11; return; end
        touch_left = 1'b0; touch_right = 1'b1; tick();
        exp_state = 2'b10;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        // R1: reset with both sensors active lands in SEARCH
        do_reset();
        check("R1", 2'b00);

        // R8: each state code reachable with its encoding
        for (int s = 0; s < 4; s++) begin
            reach(s[1:0]);
            check("R8", s[1:0]);
        end

        // Exhaustive transitions: every state with every sensor pair
        for (int s = 0; s < 4; s++) begin
            for (int in = 0; in < 4; in++) begin
                reach(s[1:0]);
                touch_left  = in[1];
                touch_right = in[0];
                tick();
                exp_state = model_next(s[1:0], in[1], in[0]);
                case (s)
                    0: check("R3", exp_state);
                    1: check("R4", exp_state);
                    2: check("R5", exp_state);
                    default: check("R6", exp_state);
                endcase
            end
        end

        // R7: sensors toggling between edges leave outputs untouched
        for (int s = 0; s < 4; s++) begin
            reach(s[1:0]);
            for (int in = 0; in < 4; in++) begin
                touch_left  = in[1];
                touch_right = in[0];
                #1;
                check("R7", s[1:0]);
            end
        end

        // R2: pseudo-random walk compared every cycle
        do_reset();
        lfsr = 8'hA5;
        for (int i = 0; i < WALK_LEN; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            touch_left  = lfsr[0];
            touch_right = lfsr[3];
            tick();
            exp_state = model_next(exp_state, lfsr[0], lfsr[3]);
            check("R2", exp_state);
        end

        // R1: reset from a non-SEARCH state mid-run
        reach(2'b10);
        do_reset();
        check("R1", 2'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule